// File: doc/BRIEF.md
# Multi-Lane Receive Framing Checker

This block watches the receive side of a multi-lane serial link after symbol decoding. Each cycle it takes one whole frame: one 8-bit symbol per lane, each with a flag that marks it as a control character. It checks the packet-delimiting rules across the frame and across frame boundaries. For every lane it reports whether the symbol broke a framing rule, which rule it broke, and whether that lane held a packet-start or packet-end delimiter.

The checker keeps two pieces of state between frames. The first records whether a packet is currently open. The second records whether the previous frame was logical idle. Inside one frame the open state is updated lane by lane from lane 0 upward, so one frame can open a packet, close it and open another. All outputs are registered and appear one cycle after the frame is presented. CRC checking and packet assembly belong to downstream logic.

Control codes (control flag set): COM = 0xBC, start delimiters 0xFB and 0x5C, end delimiters 0xFD and 0xFE, PAD = 0xF7.

Top module: `rx_frame_checker`

## Requirements
- R1: A start delimiter (control 0xFB or 0x5C) on a lane whose index is not a multiple of 4 reports error type 1 (misaligned start) on that lane.
- R2: An end delimiter (control 0xFD or 0xFE) on a lane whose index is not 3 modulo 4 reports error type 2 (misaligned end).
- R3: When the previous checked frame was logical idle (every lane data 0x00 with control flag clear), a start delimiter on any lane other than 0 reports error type 1.
- R4: A correctly placed start delimiter while a packet is already open reports error type 3 (nested start).
- R5: A correctly placed end delimiter while no packet is open reports error type 4 (orphan end).
- R6: A correctly placed, properly opened end delimiter on a lane other than the last must have a control PAD, 0xFB or 0x5C on the next lane; otherwise it reports error type 5 (bad follower).
- R7: A control COM while a packet is open reports error type 6 (unterminated) and closes the packet; a COM with no packet open is not an error.
- R8: The open state carries across frames. Within a frame it changes in ascending lane order: a start delimiter opens the packet and an end delimiter or COM closes it, whether or not the delimiter was itself an error.
- R9: While the receive-ready input is low, the frame produces all-zero outputs, the open state is cleared and the idle history is cleared.
- R10: err_o of a lane is high exactly when its type is non-zero; start_o and end_o mark the delimiter lanes; all outputs change one clock after the frame is applied, and reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_ready_i | input | 1 | Receive initialization complete; enables checking |
| sym_i | input | 8*LANES | Decoded symbols, lane l at bits [8l+7:8l] |
| ctl_i | input | LANES | Control-character flag per lane |
| err_o | output | LANES | Per-lane framing error |
| err_type_o | output | 3*LANES | Per-lane error type, lane l at bits [3l+2:3l] |
| start_o | output | LANES | Lane carried a start delimiter |
| end_o | output | LANES | Lane carried an end delimiter |

## Verification
Directed frames place each delimiter on good and bad lanes, and this separates the alignment rules from the open-state rules. Packets that span several frames, and frames that close one packet and open another, show whether the state is carried across frames and in lane order. Idle frames followed by offset starts show whether the idle history is used, and dropping ready in the middle of a packet shows whether the state is cleared. A long run of random mixed frames is then compared frame by frame against a behavioural model, which exposes any wrong priority between rules that overlap on one lane.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int SYM_W = 8;
  localparam int TYPE_W = 3;

  localparam logic [SYM_W-1:0] K_COM  = 8'hBC;
  localparam logic [SYM_W-1:0] K_STP  = 8'hFB;
  localparam logic [SYM_W-1:0] K_SDP  = 8'h5C;
  localparam logic [SYM_W-1:0] K_END  = 8'hFD;
  localparam logic [SYM_W-1:0] K_EDB  = 8'hFE;
  localparam logic [SYM_W-1:0] K_PAD  = 8'hF7;

  typedef enum logic [TYPE_W-1:0] {
    FE_NONE      = 3'd0,
    FE_START_POS = 3'd1,
    FE_END_POS   = 3'd2,
    FE_NESTED    = 3'd3,
    FE_ORPHAN    = 3'd4,
    FE_FOLLOW    = 3'd5,
    FE_UNTERM    = 3'd6
  } fe_t;

  typedef struct packed {
    logic is_start;
    logic is_end;
    logic is_com;
    logic follow_ok;
    logic is_idle;
  } sym_cls_t;
endpackage

// File: rtl/rfc_classify.sv
module rfc_classify
  import rfc_pkg::*;
(
  input  logic [SYM_W-1:0] sym_i,
  input  logic             ctl_i,
  output sym_cls_t         cls_o
);
  always_comb begin
    cls_o.is_start  = ctl_i && (sym_i == K_STP || sym_i == K_SDP);
    cls_o.is_end    = ctl_i && (sym_i == K_END || sym_i == K_EDB);
    cls_o.is_com    = ctl_i && (sym_i == K_COM);
    cls_o.follow_ok = ctl_i && (sym_i == K_PAD || sym_i == K_STP || sym_i == K_SDP);
    cls_o.is_idle   = !ctl_i && (sym_i == '0);
  end
endmodule

// File: rtl/rfc_lane_chain.sv
module rfc_lane_chain
  import rfc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int GRP   = 4
) (
  input  sym_cls_t [LANES-1:0]             cls_i,
  input  logic                             open_i,
  input  logic                             prev_idle_i,
  output logic     [LANES-1:0][TYPE_W-1:0] type_o,
  output logic                             open_o
);
  logic [LANES-1:0] ok_here;
  logic [LANES-1:0] next_ok;
  logic             open_v;

  for (genvar g = 0; g < LANES; g++) begin : g_ok
    assign ok_here[g] = cls_i[g].follow_ok;
  end

  // last lane has no neighbour to check
  if (LANES > 1) begin : g_nx
    assign next_ok = {1'b1, ok_here[LANES-1:1]};
  end else begin : g_nx1
    assign next_ok = 1'b1;
  end

  // ripple the open state from lane 0 upward
  always_comb begin
    open_v = open_i;
    for (int l = 0; l < LANES; l++) begin
      type_o[l] = FE_NONE;
      if (cls_i[l].is_start) begin
        if ((l % GRP) != 0 || (prev_idle_i && l != 0)) type_o[l] = FE_START_POS;
        else if (open_v)                               type_o[l] = FE_NESTED;
        open_v = 1'b1;
      end else if (cls_i[l].is_end) begin
        if ((l % GRP) != GRP - 1) type_o[l] = FE_END_POS;
        else if (!open_v)         type_o[l] = FE_ORPHAN;
        else if (!next_ok[l])     type_o[l] = FE_FOLLOW;
        open_v = 1'b0;
      end else if (cls_i[l].is_com) begin
        if (open_v) type_o[l] = FE_UNTERM;
        open_v = 1'b0;
      end
    end
    open_o = open_v;
  end
endmodule

// File: rtl/rx_frame_checker.sv
module rx_frame_checker
  import rfc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int GRP   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rx_ready_i,
  input  logic [LANES*SYM_W-1:0]  sym_i,
  input  logic [LANES-1:0]        ctl_i,
  output logic [LANES-1:0]        err_o,
  output logic [LANES*TYPE_W-1:0] err_type_o,
  output logic [LANES-1:0]        start_o,
  output logic [LANES-1:0]        end_o
);
  sym_cls_t [LANES-1:0]             cls;
  logic     [LANES-1:0]             idle_lane;
  logic     [LANES-1:0][TYPE_W-1:0] lane_type;
  logic                             open_q, open_d;
  logic                             idle_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rfc_classify i_cls (
      .sym_i (sym_i[g*SYM_W +: SYM_W]),
      .ctl_i (ctl_i[g]),
      .cls_o (cls[g])
    );
    assign idle_lane[g] = cls[g].is_idle;
  end

  rfc_lane_chain #(.LANES(LANES), .GRP(GRP)) i_chain (
    .cls_i       (cls),
    .open_i      (open_q),
    .prev_idle_i (idle_q),
    .type_o      (lane_type),
    .open_o      (open_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= '0;
      err_type_o <= '0;
      start_o    <= '0;
      end_o      <= '0;
      open_q     <= 1'b0;
      idle_q     <= 1'b0;
    end else if (!rx_ready_i) begin
      err_o      <= '0;
      err_type_o <= '0;
      start_o    <= '0;
      end_o      <= '0;
      open_q     <= 1'b0;
      idle_q     <= 1'b0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        err_o[l]                     <= lane_type[l] != FE_NONE;
        err_type_o[l*TYPE_W +: TYPE_W] <= lane_type[l];
        start_o[l]                   <= cls[l].is_start;
        end_o[l]                     <= cls[l].is_end;
      end
      open_q <= open_d;
      idle_q <= &idle_lane;
    end
  end

  a_r9_quiet_when_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ready_i |=> (err_o == '0 && start_o == '0 && end_o == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    a_r1_start_err_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_o[g] && err_o[g]) |->
        (err_type_o[g*TYPE_W +: TYPE_W] == FE_START_POS ||
         err_type_o[g*TYPE_W +: TYPE_W] == FE_NESTED));
    a_r2_end_err_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (end_o[g] && err_o[g]) |->
        (err_type_o[g*TYPE_W +: TYPE_W] == FE_END_POS ||
         err_type_o[g*TYPE_W +: TYPE_W] == FE_ORPHAN ||
         err_type_o[g*TYPE_W +: TYPE_W] == FE_FOLLOW));
    a_r7_unterm_not_delim: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_type_o[g*TYPE_W +: TYPE_W] == FE_UNTERM) |-> (!start_o[g] && !end_o[g]));
    a_r10_delims_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(start_o[g] && end_o[g]));
    if ((g % GRP) != 0) begin : g_sa
      a_r1_offgrid_start_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o[g] |-> (err_o[g] && err_type_o[g*TYPE_W +: TYPE_W] == FE_START_POS));
    end
    if ((g % GRP) != GRP - 1) begin : g_ea
      a_r2_offgrid_end_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        end_o[g] |-> (err_o[g] && err_type_o[g*TYPE_W +: TYPE_W] == FE_END_POS));
    end
  end
endmodule

// File: tb/test_rx_frame_checker.sv
module test_rx_frame_checker;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         rdy = 1'b0;
  logic [N*8-1:0] sym = '0;
  logic [N-1:0] ctl = '0;
  logic [N-1:0] err_o, start_o, end_o;
  logic [N*3-1:0] type_o;

  int n_vec = 0;
  int n_bad = 0;

  // behavioural reference state
  bit m_open = 0;
  bit m_idle = 0;
  int e_type [N];
  bit e_st [N];
  bit e_en [N];

  logic [N*8-1:0] fd;
  logic [N-1:0]   fc;

  always #10 clk = ~clk;

  rx_frame_checker #(.LANES(N), .GRP(4)) i_rx_frame_checker (
    .clk_i(clk), .rst_ni(rst_ni), .rx_ready_i(rdy), .sym_i(sym), .ctl_i(ctl),
    .err_o(err_o), .err_type_o(type_o), .start_o(start_o), .end_o(end_o)
  );

  function automatic string tag_of(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic clr();
    fd = {N{8'h11}};
    fc = '0;
  endtask

  task automatic put(int l, logic [7:0] b, bit k);
    fd[l*8 +: 8] = b;
    fc[l] = k;
  endtask

  task automatic model(bit r);
    bit idle;
    for (int l = 0; l < N; l++) begin
      e_type[l] = 0; e_st[l] = 0; e_en[l] = 0;
    end
    if (!r) begin
      m_open = 0; m_idle = 0;
      return;
    end
    idle = 1;
    for (int l = 0; l < N; l++) begin
      logic [7:0] b;
      bit k, st, en, cm, nok;
      b = fd[l*8 +: 8]; k = fc[l];
      if (k || b != 0) idle = 0;
      st = k && (b == 8'hFB || b == 8'h5C);
      en = k && (b == 8'hFD || b == 8'hFE);
      cm = k && (b == 8'hBC);
      nok = 1;
      if (l < N - 1)
        nok = fc[l+1] && (fd[(l+1)*8 +: 8] == 8'hF7 || fd[(l+1)*8 +: 8] == 8'hFB ||
                          fd[(l+1)*8 +: 8] == 8'h5C);
      e_st[l] = st; e_en[l] = en;
      if (st) begin
        if ((l % 4) != 0 || (m_idle && l != 0)) e_type[l] = 1;
        else if (m_open) e_type[l] = 3;
        m_open = 1;
      end else if (en) begin
        if ((l % 4) != 3) e_type[l] = 2;
        else if (!m_open) e_type[l] = 4;
        else if (!nok) e_type[l] = 5;
        m_open = 0;
      end else if (cm) begin
        if (m_open) e_type[l] = 6;
        m_open = 0;
      end
    end
    m_idle = idle;
  endtask

  // called at a negedge: apply frame, wait one edge, compare
  task automatic step(bit r, string tag);
    bit bad;
    sym = fd; ctl = fc; rdy = r;
    model(r);
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    bad = 0;
    for (int l = 0; l < N; l++) begin
      int a;
      a = int'(type_o[l*3 +: 3]);
      if (a != e_type[l] || err_o[l] != (e_type[l] != 0) ||
          start_o[l] != e_st[l] || end_o[l] != e_en[l]) begin
        bad = 1;
        $display("FAIL %s/%s lane %0d: type=%0d err=%0b st=%0b en=%0b expected type=%0d err=%0b st=%0b en=%0b",
                 tag, tag_of(e_type[l] != 0 ? e_type[l] : a), l, a, err_o[l], start_o[l], end_o[l],
                 e_type[l], e_type[l] != 0, e_st[l], e_en[l]);
      end
    end
    if (bad) n_bad++;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    n_vec++;
    if (err_o !== '0 || type_o !== '0 || start_o !== '0 || end_o !== '0) begin
      n_bad++;
      $display("FAIL R10 reset: err=%h type=%h st=%h en=%h expected all 0", err_o, type_o, start_o, end_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // R9: not ready, delimiter ignored
    clr(); put(0, 8'hFB, 1); step(0, "R9");
    // R3: idle frame then offset start
    fd = '0; fc = '0; step(1, "R3");
    clr(); put(4, 8'hFB, 1); step(1, "R3");
    clr(); put(7, 8'hFD, 1); step(1, "R8");
    // R3: idle then lane-0 start is fine, R6 PAD follower fine
    fd = '0; fc = '0; step(1, "R3");
    clr(); put(0, 8'h5C, 1); put(3, 8'hFD, 1);
    for (int l = 4; l < N; l++) put(l, 8'hF7, 1);
    step(1, "R10");
    // R1: misaligned start, then R6 bad follower
    clr(); put(2, 8'h5C, 1); step(1, "R1");
    clr(); put(3, 8'hFE, 1); step(1, "R6");
    // R2 and R5
    clr(); put(5, 8'hFD, 1); step(1, "R2");
    clr(); put(7, 8'hFD, 1); step(1, "R5");
    // R4 nested, R8 ascending update
    clr(); put(0, 8'hFB, 1); put(4, 8'hFB, 1); put(7, 8'hFE, 1); step(1, "R4");
    // R7 unterminated and harmless COM
    clr(); put(4, 8'hFB, 1); put(6, 8'hBC, 1); step(1, "R7");
    clr(); put(1, 8'hBC, 1); step(1, "R7");
    // R8 multi-frame packet with back-to-back start
    clr(); put(0, 8'hFB, 1); step(1, "R8");
    clr(); step(1, "R8");
    clr(); put(3, 8'hFD, 1); put(4, 8'hFB, 1); put(7, 8'hFD, 1); step(1, "R8");
    // R9: ready drop clears open state
    clr(); put(0, 8'hFB, 1); step(1, "R9");
    clr(); step(0, "R9");
    clr(); put(7, 8'hFD, 1); step(1, "R9");
    // R9: ready drop clears idle history
    fd = '0; fc = '0; step(1, "R9");
    clr(); step(0, "R9");
    clr(); put(4, 8'hFB, 1); step(1, "R9");

    // random mixed frames
    for (int v = 0; v < 600; v++) begin
      bit r;
      r = ($urandom_range(0, 19) != 0);
      if ($urandom_range(0, 9) == 0) begin
        fd = '0; fc = '0;
      end else begin
        for (int l = 0; l < N; l++) begin
          case ($urandom_range(0, 11))
            0: put(l, 8'hFB, 1);
            1: put(l, 8'h5C, 1);
            2: put(l, 8'hFD, 1);
            3: put(l, 8'hFE, 1);
            4: put(l, 8'hF7, 1);
            5: put(l, 8'hBC, 1);
            default: put(l, 8'($urandom_range(0, 255)), 1'($urandom_range(0, 7) == 0));
          endcase
        end
      end
      step(r, "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule